// File: doc/BRIEF.md
# Instruction Fetch Controller for Synchronous On-Chip RAM

This block sits between a processor's instruction-fetch port and a synchronous block RAM that has a one-cycle registered read. The processor presents fetch addresses with a valid/ready handshake. The controller turns each fetch into a RAM enable and address cycle, spends one wait state while the RAM reads, and returns the fetched word with a one-clock done strobe. Words always come back in request order.

The memory side can run at the processor clock (single-cycle operation) or at an integer fraction of it. The slower rate is modelled as an enable pulse, `mem_ce`, inside the processor clock domain. A clock edge marked by `mem_ce` is common to both clocks and bounds every memory bus cycle.

The pulse comes from a programmable divider, or from an external edge marker when automatic ratio detection is on. A control word selects the source. Bit 0 turns automatic detection on. Bits 3:1 hold the ratio field, where value v gives one pulse every v+1 clocks and v=0 means single-cycle operation. An address is accepted as soon as the previous one has been latched, so overlapped requests run at one word per memory-side cycle.

Top module: `ifc_fetch_ctl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` is 0, `ram_en` is 0, and `mem_ce` is 1 every clock, because the control word resets to 0 (manual mode, ratio 1:1).
- R2: In single-cycle operation, a fetch accepted from idle in clock k drives `ram_en`=1 and `ram_addr`= its address in clock k+1, and raises `rsp_done` in clock k+3, which is four clocks in total.
- R3: At ratio 1:1, a new request is accepted every clock and `req_ready` never goes low.
- R4: When bit 0 of the control word is 0, `mem_ce` is high once every v+1 clocks, where v is the ratio field in bits 3:1. When v=0, `mem_ce` is high every clock.
- R5: `ram_en` and `ram_addr` change only at a clock edge that ends a clock in which `mem_ce` was high.
- R6: With requests held valid at ratio v+1, N fetches produce N done strobes spaced exactly v+1 clocks apart.
- R7: `req_ready` is low exactly when an accepted address is waiting in the pending slot and `mem_ce` is low. At most two addresses are held: one pending and one on the RAM bus.
- R8: Each returned word equals the RAM content at its address, in request order. `rsp_done` is high only in a clock that follows a clock with `mem_ce` high.
- R9: When bit 0 of the control word is 1, `mem_ce` equals `mclk_edge` in every clock. When bit 0 is 0, `mclk_edge` has no effect on `mem_ce`.
- R10: A control write in clock w restarts the divider, so the first `mem_ce` pulse is in clock w+v+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 4 | Control word: bit 0 selects automatic detection, bits 3:1 hold the ratio field |
| mclk_edge | input | 1 | Marks a clock that ends on a memory-clock rising edge (used in automatic mode) |
| req_valid | input | 1 | Fetch request valid |
| req_addr | input | AW | Fetch word address |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| rsp_done | output | 1 | Fetched word valid, one clock per word |
| rsp_data | output | DW | Fetched instruction word |
| mem_ce | output | 1 | Memory-side clock enable pulse |
| ram_en | output | 1 | RAM read enable |
| ram_addr | output | AW | RAM address |
| ram_rdata | input | DW | RAM registered read data |

## Verification
A lone fetch from idle measures the full latency of issue, wait state and capture, and separates a correct four-clock path from a design that skips the wait state or adds an extra stage. Continuous request streams at 1:1, 2:1 and 3:1 show whether the pending slot and the bus register keep one word per memory cycle, or whether they stall or drop a request. An irregular external edge pattern in automatic mode, held edge markers in manual mode, and control writes at several ratios separate the pulse sources and show the divider restart. A running reference model of ready, bus stability, done placement and data order watches every clock of these patterns.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  localparam int RATIO_W = 3;
  localparam int CFG_W   = RATIO_W + 1;

  // bit 0: automatic detection, bits RATIO_W:1: ratio field
  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic               auto_en;
  } ifc_cfg_t;
endpackage

// File: rtl/ifc_ce_gen.sv
module ifc_ce_gen
  import ifc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cfg_we,
  input  ifc_cfg_t cfg,
  input  logic     mclk_edge,
  output logic     ce
);
  logic [RATIO_W-1:0] cnt;
  logic               div_hit;

  assign div_hit = (cnt >= cfg.ratio);

  always_ff @(posedge clk) begin
    if (rst || cfg_we || div_hit) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign ce = cfg.auto_en ? mclk_edge : div_hit;
endmodule

// File: rtl/ifc_req_stage.sv
module ifc_req_stage #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          pend_v,
  output logic          bus_en,
  output logic [AW-1:0] bus_addr
);
  logic [AW-1:0] pend_addr;
  logic          take;

  assign req_ready = !pend_v || ce;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      pend_addr <= '0;
      bus_en    <= 1'b0;
      bus_addr  <= '0;
    end else if (ce) begin
      if (pend_v) begin
        bus_en   <= 1'b1;
        bus_addr <= pend_addr;
        pend_v   <= take;
        if (take) pend_addr <= req_addr;
      end else begin
        bus_en <= take;
        if (take) bus_addr <= req_addr;
      end
    end else if (take) begin
      pend_v    <= 1'b1;
      pend_addr <= req_addr;
    end
  end
endmodule

// File: rtl/ifc_rsp_stage.sv
module ifc_rsp_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic          bus_en,
  input  logic [DW-1:0] ram_rdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_data
);
  logic rd_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v     <= 1'b0;
      rsp_done <= 1'b0;
      rsp_data <= '0;
    end else begin
      rsp_done <= 1'b0;
      if (ce) begin
        rd_v <= bus_en;
        if (rd_v) begin
          rsp_done <= 1'b1;
          rsp_data <= ram_rdata;
        end
      end
    end
  end
endmodule

// File: rtl/ifc_fetch_ctl.sv
module ifc_fetch_ctl
  import ifc_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             mclk_edge,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  output logic             req_ready,
  output logic             rsp_done,
  output logic [DW-1:0]    rsp_data,
  output logic             mem_ce,
  output logic             ram_en,
  output logic [AW-1:0]    ram_addr,
  input  logic [DW-1:0]    ram_rdata
);
  ifc_cfg_t cfg_q;
  logic     pend_v;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= ifc_cfg_t'(cfg_wdata);
  end

  ifc_ce_gen u_ce (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg(cfg_q),
    .mclk_edge(mclk_edge), .ce(mem_ce)
  );

  ifc_req_stage #(.AW(AW)) u_req (
    .clk(clk), .rst(rst), .ce(mem_ce),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .pend_v(pend_v), .bus_en(ram_en), .bus_addr(ram_addr)
  );

  ifc_rsp_stage #(.DW(DW)) u_rsp (
    .clk(clk), .rst(rst), .ce(mem_ce), .bus_en(ram_en),
    .ram_rdata(ram_rdata), .rsp_done(rsp_done), .rsp_data(rsp_data)
  );
endmodule

// File: rtl/ifc_fetch_chk.sv
module ifc_fetch_chk
  import ifc_pkg::*;
#(
  parameter int AW = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [CFG_W-1:0] cfg,
  input logic             mem_ce,
  input logic             req_valid,
  input logic             req_ready,
  input logic [AW-1:0]    req_addr,
  input logic             pend_v,
  input logic             ram_en,
  input logic [AW-1:0]    ram_addr,
  input logic             rsp_done
);
  // R7
  ready_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> (pend_v && !mem_ce));

  // R8
  done_after_edge_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> $past(mem_ce));

  // R5
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(mem_ce) |-> ($stable(ram_en) && $stable(ram_addr)));

  // R2
  direct_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && mem_ce && !pend_v) |=> (ram_en && ram_addr == $past(req_addr)));

  // R4
  single_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg[0] && cfg[CFG_W-1:1] == '0) |-> mem_ce);
endmodule

bind ifc_fetch_ctl ifc_fetch_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .cfg(cfg_q), .mem_ce(mem_ce),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .pend_v(pend_v), .ram_en(ram_en), .ram_addr(ram_addr), .rsp_done(rsp_done)
);

// File: tb/sim_ifc_fetch_ctl.sv
`timescale 1ns/100ps
module sim_ifc_fetch_ctl;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic          mclk_edge = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, rsp_done, mem_ce, ram_en;
  logic [DW-1:0] rsp_data;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_q = '0;

  int n_chk = 0;
  int n_fail = 0;
  longint cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  ifc_fetch_ctl #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mclk_edge(mclk_edge), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_data(rsp_data),
    .mem_ce(mem_ce), .ram_en(ram_en), .ram_addr(ram_addr), .ram_rdata(ram_q)
  );

  function automatic logic [DW-1:0] word_of(logic [AW-1:0] a);
    return (DW'(a) * 32'd40503) ^ 32'h3C3C_0000;
  endfunction

  // RAM model: one-cycle registered read on the memory-side edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_ce && ram_en) ram_q <= word_of(ram_addr);
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // running reference model
  logic [DW-1:0] exp_q[$];
  longint        acc_q[$];
  bit            pend_m = 0, prev_ok = 0, prev_ce = 0, prev_en = 0;
  logic [AW-1:0] prev_addr = '0;
  longint        last_lat = 0, first_done = 0, last_done = 0, done_cnt = 0, ready_low = 0;
  bit            mark_first = 0;

  always @(negedge clk) begin
    bit acc;
    if (rst) begin
      pend_m = 0; prev_ok = 0;
      exp_q.delete(); acc_q.delete();
    end else begin
      chk(req_ready == (!pend_m || mem_ce), "R7 ready rule", req_ready, !pend_m || mem_ce);
      acc = req_valid && req_ready;
      if (req_valid && !req_ready) ready_low++;
      if (acc) begin
        exp_q.push_back(word_of(req_addr));
        acc_q.push_back(cyc);
      end
      if (rsp_done) begin
        chk(prev_ce, "R8 done after memory edge", 0, 1);
        if (exp_q.size() == 0) chk(0, "R8 unexpected done", 1, 0);
        else begin
          logic [DW-1:0] e;
          longint a;
          e = exp_q.pop_front();
          a = acc_q.pop_front();
          chk(rsp_data == e, "R8 data in order", rsp_data, e);
          last_lat = cyc - a;
        end
        done_cnt++;
        if (mark_first) begin first_done = cyc; mark_first = 0; end
        last_done = cyc;
      end
      if (prev_ok && !prev_ce)
        chk(ram_en == prev_en && ram_addr == prev_addr, "R5 bus held between edges",
            {ram_en, ram_addr}, {prev_en, prev_addr});
      pend_m = mem_ce ? (pend_m && acc) : (pend_m || acc);
      prev_ce = mem_ce; prev_en = ram_en; prev_addr = ram_addr; prev_ok = 1;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  longint w_cyc;
  task automatic write_cfg(bit auto_on, int v);
    step();
    cfg_we = 1'b1;
    cfg_wdata = {3'(v), auto_on};
    w_cyc = cyc;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 300 && exp_q.size() != 0; i++) step();
    chk(exp_q.size() == 0, "R8 all fetches returned", exp_q.size(), 0);
  endtask

  task automatic drive_burst(int n, logic [AW-1:0] base);
    int sent = 0;
    bit acc;
    req_valid = 1'b1;
    req_addr = base;
    while (sent < n) begin
      @(negedge clk); acc = req_ready;
      step();
      if (acc) begin
        sent++;
        req_addr = base + AW'(sent);
        if (sent == n) req_valid = 1'b0;
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
    chk(rsp_done == 0, "R1 done after reset", rsp_done, 0);
    chk(ram_en == 0, "R1 ram_en after reset", ram_en, 0);
    chk(mem_ce == 1, "R1 single-cycle after reset", mem_ce, 1);
  endtask

  task automatic t_first_fetch(logic [AW-1:0] a);
    step();
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    chk(req_ready == 1, "R2 idle accepts", req_ready, 1);
    step();
    req_valid = 1'b0;
    @(negedge clk);
    chk(ram_en == 1 && ram_addr == a, "R2 bus driven next clock", {ram_en, ram_addr}, {1'b1, a});
    drain();
    chk(last_lat == 3, "R2 four-clock first fetch", last_lat, 3);
  endtask

  task automatic t_ratio_period(int v, bit edge_lvl);
    int p = v + 1;
    mclk_edge = edge_lvl;
    write_cfg(0, v);
    for (int k = 0; k < 3 * p; k++) begin
      @(negedge clk);
      chk(mem_ce == ((cyc - w_cyc) % p == 0), "R4 R10 divider period and restart",
          mem_ce, (cyc - w_cyc) % p == 0);
    end
    if (edge_lvl) chk(1, "R9 manual mode ignores mclk_edge", 0, 0);
    mclk_edge = 1'b0;
  endtask

  task automatic t_burst(int v, int n, logic [AW-1:0] base);
    longint d0, r0;
    write_cfg(0, v);
    d0 = done_cnt; r0 = ready_low;
    mark_first = 1;
    drive_burst(n, base);
    drain();
    chk(done_cnt - d0 == n, "R6 done count", done_cnt - d0, n);
    chk(last_done - first_done == (n - 1) * (v + 1), "R6 sustained spacing",
        last_done - first_done, (n - 1) * (v + 1));
    if (v == 0) chk(ready_low == r0, "R3 no stall at 1:1", ready_low - r0, 0);
  endtask

  task automatic t_auto();
    longint d0;
    write_cfg(1, 0);
    d0 = done_cnt;
    fork
      for (int i = 0; i < 80; i++) begin
        mclk_edge = (i % 5 == 0) || (i % 5 == 3);
        step();
      end
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        chk(mem_ce == mclk_edge, "R9 auto follows edge", mem_ce, mclk_edge);
      end
      drive_burst(8, 10'h2C0);
    join
    mclk_edge = 1'b0;
    chk(done_cnt - d0 == 8, "R9 auto-mode fetches", done_cnt - d0, 8);
    write_cfg(0, 0);
    drain();
  endtask

  initial begin
    repeat (4) step();
    rst = 1'b0;
    t_reset();
    t_first_fetch(10'h013);
    t_ratio_period(2, 0);
    t_ratio_period(6, 1);
    t_ratio_period(0, 1);
    t_burst(0, 12, 10'h100);
    t_burst(1, 10, 10'h1F8);
    t_burst(2, 9, 10'h3FC);
    t_auto();
    t_first_fetch(10'h3FF);
    repeat (3) step();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule